// File: doc/BRIEF.md
# Sensor Wiring Fault-Check Sequencer

This block runs the host-requested wiring check of a resistive temperature sensor front end. A configuration byte arrives over a valid/ready port. When it asks for a fault cycle, the block forces the converter into its normally-off mode and walks through a fixed sequence. It drives the low-side return switch, waits for settling where required, and samples three one-bit comparator flags on single clock edges. Any flag found true is latched into a sticky fault-status byte.

Two cycle modes exist. In the automatic mode the block times both settling intervals itself, counted in clock cycles derived from a clock-frequency parameter. In the manual mode the host owns the timing. A first write runs the closed-switch check and leaves the switch open. A second write runs the open-switch checks and closes the switch again. A two-bit progress field reads back the running step and clears itself to 00 when the cycle ends. The comparators, the converter and the register file sit outside the block.

Configuration writes use a simple handshake. A write is taken on a rising edge where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is low while a step is running. While `cfg_ready` is low, the host must hold `cfg_valid` and `cfg_data` steady.

Top module: `rtd_fltcyc_seq`

## Requirements
- R1: After reset the progress field is 00, the return switch is closed (`ret_sw_open`=0), `fault_status` and `rtd_fault` are 0, and `cfg_ready` is 1.
- R2: A write starts a cycle only when bit 7 (bias on) is 1, bit 6 (continuous mode) is 0, bit 5 (one-shot) is 0, and the cycle field in bits [3:2] is non-zero. Any other write leaves the progress field at 00 and raises no force pulse.
- R3: A write that sets the one-shot bit together with either cycle-field bit is ignored as a whole: no cycle starts and no force pulse appears.
- R4: Field 01 runs the automatic cycle, with the progress field reading 01 throughout. The switch stays closed for SETTLE cycles, and on the last edge of that interval the REFIN-high flag is sampled into status bit 5. The switch then opens for SETTLE more cycles. On the last edge of this second interval, the REFIN-low flag is sampled into bit 4 and the RTDIN-low flag into bit 3. The switch then closes and the field returns to 00.
- R5: Field 10 runs manual step 1. The field reads 10 in the cycle after the write. On the next edge the REFIN-high flag is sampled into bit 5 and the switch opens. The field then stays at 10 until a step-2 write arrives.
- R6: Field 11, written while step 1 is holding, runs manual step 2. The field reads 11 for one cycle. The low flags are then sampled into bits 4 and 3, the switch closes and the field returns to 00.
- R7: Field 11 written while idle runs the full automatic cycle of R4, and the field reads 01.
- R8: Status bits are sticky. They are ORed in when sampled and never cleared by the block; only reset clears them.
- R9: `rtd_fault` (bit 0 of the low result byte) is 1 whenever any of status bits 5..3 is 1.
- R10: Every accepted command, whether a start from idle or a step-2 write, pulses `force_single_mode` high for exactly the cycle after the accepting edge.
- R11: `cfg_ready` is low while the automatic cycle or a manual step runs, and high while idle or holding after step 1. While holding, a write that is not a valid step-2 command is consumed with no effect.
- R12: Comparator flags affect status only on their sampling edge. A flag that is high only at other times changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration write valid |
| cfg_ready | output | 1 | Block can take a configuration write |
| cfg_data | input | 8 | Configuration byte |
| cmp_refn_high | input | 1 | Comparator: REFIN- above 85 % of bias |
| cmp_refn_low | input | 1 | Comparator: REFIN- below 85 % of bias |
| cmp_rtdn_low | input | 1 | Comparator: RTDIN- below 85 % of bias |
| ret_sw_open | output | 1 | 1 opens the low-side return switch |
| cycle_field | output | 2 | Progress field (00 idle, 01 auto, 10 manual step 1, 11 manual step 2) |
| force_single_mode | output | 1 | One-cycle pulse forcing normally-off conversion mode |
| fault_status | output | 8 | Sticky fault bits 5..3; other bits 0 |
| rtd_fault | output | 1 | Fault flag for bit 0 of the low result byte |

## Verification
The assertions take for granted that `cfg_valid` and `cfg_data` stay stable while `cfg_ready` is low. They also assume the comparator flags are clean, synchronous levels. The step-1 hold property further assumes the host does not leave `cfg_valid` asserted with an unrelated write. The stimulus drives every input on the falling clock edge. Its write task raises `cfg_valid` only after it has seen `cfg_ready` high and drops it right after the accepting edge. Flags change only on falling edges and are pulsed deliberately off their sampling edges to exercise R12.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AUTO_CLOSED,
    ST_AUTO_OPEN,
    ST_MAN1,
    ST_MAN_WAIT,
    ST_MAN2
  } seq_state_t;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_AUTO,
    CMD_STEP1,
    CMD_STEP2
  } cmd_t;

  localparam logic [1:0] FLD_IDLE = 2'b00;
  localparam logic [1:0] FLD_AUTO = 2'b01;
  localparam logic [1:0] FLD_MAN1 = 2'b10;
  localparam logic [1:0] FLD_MAN2 = 2'b11;

  localparam int CFG_W       = 8;
  localparam int CFG_BIAS    = 7;
  localparam int CFG_CONT    = 6;
  localparam int CFG_ONESHOT = 5;
  localparam int CFG_FLD_LO  = 2;

  localparam int N_FLAGS     = 3;
  localparam int STAT_LSB    = 3;
endpackage

// File: rtl/rfc_cfg_decode.sv
module rfc_cfg_decode
  import rfc_pkg::*;
(
  input  logic [CFG_W-1:0] data,
  output cmd_t             cmd
);
  logic [1:0] fld;
  logic       legal;
  logic       unused_bits;

  assign fld         = data[CFG_FLD_LO+1:CFG_FLD_LO];
  assign legal       = data[CFG_BIAS] & ~data[CFG_CONT] & ~data[CFG_ONESHOT];
  assign unused_bits = ^{data[4], data[1:0]};

  always_comb begin
    cmd = CMD_NONE;
    if (legal) begin
      unique case (fld)
        FLD_AUTO: cmd = CMD_AUTO;
        FLD_MAN1: cmd = CMD_STEP1;
        FLD_MAN2: cmd = CMD_STEP2;
        default:  cmd = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/rfc_settle_timer.sv
module rfc_settle_timer #(
  parameter int LIMIT = 12500,
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= CNT_W'(LIMIT - 1);
    else if (run && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = run && (cnt == '0);
endmodule

// File: rtl/rfc_seq_fsm.sv
module rfc_seq_fsm
  import rfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  cmd_t       cmd,
  input  logic       tmr_done,
  output seq_state_t state,
  output logic       ready,
  output logic       tmr_load,
  output logic       tmr_run,
  output logic       samp_closed,
  output logic       samp_open,
  output logic       cmd_acc
);
  seq_state_t nxt;

  always_comb begin
    nxt         = state;
    tmr_load    = 1'b0;
    samp_closed = 1'b0;
    samp_open   = 1'b0;
    cmd_acc     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (take && (cmd == CMD_AUTO || cmd == CMD_STEP2)) begin
          nxt      = ST_AUTO_CLOSED;
          tmr_load = 1'b1;
          cmd_acc  = 1'b1;
        end else if (take && cmd == CMD_STEP1) begin
          nxt     = ST_MAN1;
          cmd_acc = 1'b1;
        end
      end
      ST_AUTO_CLOSED: begin
        if (tmr_done) begin
          nxt         = ST_AUTO_OPEN;
          tmr_load    = 1'b1;
          samp_closed = 1'b1;
        end
      end
      ST_AUTO_OPEN: begin
        if (tmr_done) begin
          nxt       = ST_IDLE;
          samp_open = 1'b1;
        end
      end
      ST_MAN1: begin
        nxt         = ST_MAN_WAIT;
        samp_closed = 1'b1;
      end
      ST_MAN_WAIT: begin
        if (take && cmd == CMD_STEP2) begin
          nxt     = ST_MAN2;
          cmd_acc = 1'b1;
        end
      end
      ST_MAN2: begin
        nxt       = ST_IDLE;
        samp_open = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign ready   = (state == ST_IDLE) || (state == ST_MAN_WAIT);
  assign tmr_run = (state == ST_AUTO_CLOSED) || (state == ST_AUTO_OPEN);
endmodule

// File: rtl/rtd_fltcyc_seq.sv
module rtd_fltcyc_seq
  import rfc_pkg::*;
#(
  parameter int CLK_HZ    = 125_000_000,
  parameter int SETTLE_US = 100,
  localparam int RAW_CYC    = (CLK_HZ / 1_000_000) * SETTLE_US,
  localparam int SETTLE_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             cmp_refn_high,
  input  logic             cmp_refn_low,
  input  logic             cmp_rtdn_low,
  output logic             ret_sw_open,
  output logic [1:0]       cycle_field,
  output logic             force_single_mode,
  output logic [7:0]       fault_status,
  output logic             rtd_fault
);
  cmd_t       cmd;
  seq_state_t state;
  logic       take, tmr_load, tmr_run, tmr_done;
  logic       samp_closed, samp_open, cmd_acc;
  logic       force_q;
  logic [N_FLAGS-1:0] flag_in, flag_en, flag_q;

  assign take = cfg_valid && cfg_ready;

  rfc_cfg_decode u_dec (
    .data (cfg_data),
    .cmd  (cmd)
  );

  rfc_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .cmd         (cmd),
    .tmr_done    (tmr_done),
    .state       (state),
    .ready       (cfg_ready),
    .tmr_load    (tmr_load),
    .tmr_run     (tmr_run),
    .samp_closed (samp_closed),
    .samp_open   (samp_open),
    .cmd_acc     (cmd_acc)
  );

  rfc_settle_timer #(.LIMIT(SETTLE_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .run   (tmr_run),
    .done  (tmr_done)
  );

  // flag index 2 -> status bit 5, 1 -> bit 4, 0 -> bit 3
  assign flag_in = {cmp_refn_high, cmp_refn_low, cmp_rtdn_low};
  assign flag_en = {samp_closed, samp_open, samp_open};

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flag_q[i] <= 1'b0;
      else if (flag_en[i] && flag_in[i])
        flag_q[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) force_q <= 1'b0;
    else        force_q <= cmd_acc;
  end

  always_comb begin
    unique case (state)
      ST_AUTO_CLOSED, ST_AUTO_OPEN: cycle_field = FLD_AUTO;
      ST_MAN1, ST_MAN_WAIT:         cycle_field = FLD_MAN1;
      ST_MAN2:                      cycle_field = FLD_MAN2;
      default:                      cycle_field = FLD_IDLE;
    endcase
  end

  assign ret_sw_open       = (state == ST_AUTO_OPEN) || (state == ST_MAN_WAIT) ||
                             (state == ST_MAN2);
  assign force_single_mode = force_q;
  assign fault_status      = {2'b00, flag_q, 3'b000};
  assign rtd_fault         = |flag_q;
endmodule

// File: rtl/rfc_seq_checks.sv
module rfc_seq_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_valid,
  input logic       cfg_ready,
  input logic [7:0] cfg_data,
  input logic       ret_sw_open,
  input logic [1:0] cycle_field,
  input logic       force_single_mode,
  input logic [2:0] flt,
  input logic       rtd_fault
);
  a_r4_idle_switch_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_field == 2'b00) |-> !ret_sw_open);

  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_field == 2'b01 || cycle_field == 2'b11) |-> !cfg_ready);

  a_r5_step1_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_field == 2'b10 && ret_sw_open && !cfg_valid) |=> (cycle_field == 2'b10));

  a_r8_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flt) & ~flt) == 3'b000));

  a_r9_fault_rises_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rtd_fault) |-> ($past(cycle_field) != 2'b00));

  a_r10_force_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cycle_field) == 2'b00 && cycle_field != 2'b00) |-> force_single_mode);

  a_r3_oneshot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready && cfg_data[5]) |=> !force_single_mode);

  a_r2_no_start_bias_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready && !cfg_data[7] && cycle_field == 2'b00) |=>
      (cycle_field == 2'b00));
endmodule

bind rtd_fltcyc_seq rfc_seq_checks u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .cfg_valid         (cfg_valid),
  .cfg_ready         (cfg_ready),
  .cfg_data          (cfg_data),
  .ret_sw_open       (ret_sw_open),
  .cycle_field       (cycle_field),
  .force_single_mode (force_single_mode),
  .flt               (fault_status[5:3]),
  .rtd_fault         (rtd_fault)
);

// File: tb/rtd_fltcyc_seq_test.sv
module rtd_fltcyc_seq_test;
  localparam int S = 6;   // 1 MHz parameter clock x 6 us

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_valid = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       cmp_refn_high = 1'b0, cmp_refn_low = 1'b0, cmp_rtdn_low = 1'b0;
  logic       cfg_ready, ret_sw_open, force_single_mode, rtd_fault;
  logic [1:0] cycle_field;
  logic [7:0] fault_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [1:0] prev_field = 2'b00;

  always #4 clk = ~clk;

  rtd_fltcyc_seq #(.CLK_HZ(1_000_000), .SETTLE_US(S)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_data(cfg_data), .cmp_refn_high(cmp_refn_high), .cmp_refn_low(cmp_refn_low),
    .cmp_rtdn_low(cmp_rtdn_low), .ret_sw_open(ret_sw_open), .cycle_field(cycle_field),
    .force_single_mode(force_single_mode), .fault_status(fault_status),
    .rtd_fault(rtd_fault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // driver: expected end-of-cycle status goes to the scoreboard before the write
  task automatic push_exp(input logic [7:0] st);
    exp_q.push_back(st);
  endtask

  // returns at the falling edge right after the accepting rising edge
  task automatic put_cfg(input logic [7:0] d);
    @(negedge clk);
    while (!cfg_ready) @(negedge clk);
    cfg_valid = 1'b1;
    cfg_data  = d;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  // monitor: a cycle ends when the progress field drops back to 00
  always @(negedge clk) begin
    if (!rst_n) prev_field <= 2'b00;
    else begin
      if (prev_field != 2'b00 && cycle_field == 2'b00) begin
        if (exp_q.size() == 0) chk("R4 scoreboard underflow", 1, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk("R8 status at cycle end", {24'd0, fault_status}, {24'd0, e});
          chk("R9 fault flag", {31'd0, rtd_fault}, {31'd0, (e != 8'h00)});
        end
      end
      prev_field <= cycle_field;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state (reset held from time zero)
    chk("R1 field", cycle_field, 2'b00);
    chk("R1 switch", ret_sw_open, 1'b0);
    chk("R1 status", fault_status, 8'h00);
    chk("R1 fault", rtd_fault, 1'b0);
    chk("R1 ready", cfg_ready, 1'b1);
    rst_n = 1'b1;

    // R2 writes that must not start: bias off, continuous on, field 00
    put_cfg(8'h04);
    chk("R2 bias off field", cycle_field, 2'b00);
    chk("R2 bias off force", force_single_mode, 1'b0);
    put_cfg(8'hC4);
    chk("R2 continuous field", cycle_field, 2'b00);
    chk("R2 continuous force", force_single_mode, 1'b0);
    put_cfg(8'h80);
    chk("R2 field 00", cycle_field, 2'b00);

    // R3 one-shot with cycle bit
    put_cfg(8'hA4);
    chk("R3 oneshot field", cycle_field, 2'b00);
    chk("R3 oneshot force", force_single_mode, 1'b0);
    put_cfg(8'hA8);
    chk("R3 oneshot manual field", cycle_field, 2'b00);

    // R4 automatic cycle, REFIN-high true
    cmp_refn_high = 1'b1;
    push_exp(8'h20);
    put_cfg(8'h85);
    chk("R4 field auto", cycle_field, 2'b01);
    chk("R10 force pulse", force_single_mode, 1'b1);
    chk("R11 ready low", cfg_ready, 1'b0);
    chk("R4 switch closed", ret_sw_open, 1'b0);
    @(negedge clk);
    chk("R10 pulse one cycle", force_single_mode, 1'b0);
    repeat (S - 2) @(negedge clk);
    chk("R4 closed end of settle", ret_sw_open, 1'b0);
    chk("R12 not yet sampled", fault_status, 8'h00);
    @(negedge clk);
    chk("R4 switch opens", ret_sw_open, 1'b1);
    chk("R4 bit5 sampled", fault_status, 8'h20);
    cmp_refn_high = 1'b0;
    repeat (S - 1) @(negedge clk);
    chk("R4 still auto", cycle_field, 2'b01);
    @(negedge clk);
    chk("R4 switch closes", ret_sw_open, 1'b0);
    chk("R4 field cleared", cycle_field, 2'b00);

    // R8 second auto cycle ORs in the low flags
    cmp_refn_low = 1'b1; cmp_rtdn_low = 1'b1;
    push_exp(8'h38);
    put_cfg(8'h84);
    repeat (2 * S) @(negedge clk);
    chk("R8 cumulative", fault_status, 8'h38);
    cmp_refn_low = 1'b0; cmp_rtdn_low = 1'b0;
    put_cfg(8'h84);
    push_exp(8'h38);
    repeat (2 * S) @(negedge clk);
    chk("R8 not cleared by clean cycle", fault_status, 8'h38);

    // R12 flag pulse away from sampling edges
    do_reset();
    push_exp(8'h00);
    put_cfg(8'h84);
    @(negedge clk); cmp_refn_high = 1'b1; cmp_refn_low = 1'b1;
    repeat (2) @(negedge clk); cmp_refn_high = 1'b0; cmp_refn_low = 1'b0;
    repeat (2 * S) @(negedge clk);
    chk("R12 off-edge pulse ignored", fault_status, 8'h00);

    // R5/R6 manual mode
    do_reset();
    push_exp(8'h08);
    put_cfg(8'h88);
    chk("R5 field step1", cycle_field, 2'b10);
    chk("R5 switch closed", ret_sw_open, 1'b0);
    chk("R10 force manual", force_single_mode, 1'b1);
    @(negedge clk);
    chk("R5 switch opens", ret_sw_open, 1'b1);
    chk("R5 ready holding", cfg_ready, 1'b1);
    cmp_refn_high = 1'b1; cmp_refn_low = 1'b1;
    repeat (10) @(negedge clk);
    chk("R5 field holds", cycle_field, 2'b10);
    chk("R12 flags while holding", fault_status, 8'h00);
    cmp_refn_high = 1'b0; cmp_refn_low = 1'b0;
    put_cfg(8'h84);
    chk("R11 non-step2 ignored field", cycle_field, 2'b10);
    chk("R11 non-step2 no force", force_single_mode, 1'b0);
    cmp_rtdn_low = 1'b1;
    put_cfg(8'h8C);
    chk("R6 field step2", cycle_field, 2'b11);
    chk("R6 switch open", ret_sw_open, 1'b1);
    chk("R10 force step2", force_single_mode, 1'b1);
    @(negedge clk);
    chk("R6 field cleared", cycle_field, 2'b00);
    chk("R6 switch closed", ret_sw_open, 1'b0);
    cmp_rtdn_low = 1'b0;

    // R7 step 2 without step 1 runs the automatic cycle
    do_reset();
    cmp_refn_low = 1'b1;
    push_exp(8'h10);
    put_cfg(8'h8C);
    chk("R7 field auto", cycle_field, 2'b01);
    repeat (S - 1) @(negedge clk);
    chk("R7 closed first interval", ret_sw_open, 1'b0);
    @(negedge clk);
    chk("R7 opens", ret_sw_open, 1'b1);
    repeat (S) @(negedge clk);
    chk("R7 done", cycle_field, 2'b00);
    cmp_refn_low = 1'b0;

    repeat (3) @(negedge clk);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule